// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block sits between a processor-side byte port and a simple block-wide memory port and keeps copies of recently used memory blocks in local storage. An incoming byte address is cut into three fields: the upper bits form the tag, the middle bits pick a set, and the lowest bits select a byte inside the block. Set count, ways per set and block size are powers of two fixed by parameters. Each way holds a valid flag, a dirty flag, a tag and one block of data. Within a set, ways are ranked by how recently they were used.

Every processor access ends with a single-cycle completion pulse that says whether it hit. Two free-running counters record hits and misses. A miss fetches the whole block from memory. A parameter picks one of two write policy pairings. In the first, writes stay in the cache, and a dirty block goes back to memory only when it is evicted; a write miss brings the block in first. In the second, every write goes to memory at once, and a write miss does not load the block. While a memory transfer is outstanding the block raises a busy flag and ignores new requests.

Top module: `cache_ctrl`

## Requirements
- R1: An access hits only when a way in the selected set is valid and its stored tag equals the address tag. A read returns the byte at the block offset, where bit 0 of the address picks the byte within a 2-byte block.
- R2: With 4-bit addresses, 2-byte blocks, 4 sets and 1 way, byte reads of addresses 0, 1, 7, 8, 0 report miss, hit, miss, miss, miss.
- R3: With 4-bit addresses, 2-byte blocks, 2 sets and 2 ways, the same read sequence reports miss, hit, miss, miss, hit.
- R4: On a miss, the lowest-numbered invalid way in the set is filled first. When no way is invalid, the least recently used way is replaced.
- R5: In write-back mode, a write hit changes only the cached byte, marks the line dirty and issues no memory transfer.
- R6: When a miss evicts a dirty line, the old block is written to memory (all bytes enabled) before the read of the new block is issued.
- R7: In write-back mode, a write miss first reads the block from memory and then updates the byte in the cache, with no memory write.
- R8: In write-through mode, a write hit updates the cached byte and also writes that single byte to memory before the completion pulse. mem_wmask bit i enables byte i of the block, and byte i sits at mem_wdata[8i+7:8i].
- R9: In write-through mode, a write miss writes the byte to memory and does not load the block, so a later read of that block still misses.
- R10: Reset clears all valid and dirty flags and both counters, and leaves busy, completion and memory request low.
- R11: Each access adds exactly one to either the hit counter or the miss counter, never to both.
- R12: Busy stays high for as long as a memory transfer is outstanding. Once raised, the memory request and its address and direction stay unchanged until mem_ack. mem_addr is the block address, which is the byte address shifted right by the offset width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken while not busy |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_busy | output | 1 | A miss or write is being served |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Hit flag valid with cpu_done |
| cpu_rdata | output | 8 | Read byte valid with cpu_done |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write to memory, 0 = block read |
| mem_addr | output | ADDR_W-OFF_BITS | Block address |
| mem_wdata | output | 8<<OFF_BITS | Block write data |
| mem_wmask | output | 1<<OFF_BITS | Byte enables for memory writes |
| mem_ack | input | 1 | Transfer complete, one cycle |
| mem_rdata | input | 8<<OFF_BITS | Block read data, valid with mem_ack |

## Verification
In write-through mode, one accepted write both changes the cached byte and starts a memory store, so the line update and the store to memory overlap. The bench triggers this with a write hit on the 2-way write-through instance. It then checks the memory model contents after the completion pulse and follows with a read hit that must return the new byte. In write-back mode, the dirty write-back and the fill come from the same miss. The memory model's operation log must show them in order: write first, then read.

// File: rtl/cache_pkg.sv
package cache_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_FINISH,
        ST_WTHRU
    } cache_state_e;

    // Width of an index field that may have zero bits
    function automatic int unsigned idx_w(input int unsigned bits);
        return (bits > 0) ? bits : 1;
    endfunction

endpackage

// File: rtl/cache_lookup.sv
module cache_lookup #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1,
    parameter int TAG_W = 2
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]      tag,
    input  logic [WAYS*WAY_W-1:0] ages,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic [WAY_W-1:0]      victim_way
);
    logic [WAYS-1:0] match;
    logic            found;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g*TAG_W +: TAG_W] == tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    // Empty ways first (lowest index), otherwise the oldest way
    always_comb begin
        victim_way = '0;
        found      = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid[w]) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (ages[w*WAY_W +: WAY_W] == WAY_W'(WAYS-1)) victim_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
    parameter int SETS     = 4,
    parameter int SET_BITS = 2,
    parameter int WAYS     = 2,
    parameter int WAY_W    = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SET_BITS-1:0]   rd_set,
    input  logic                  touch,
    input  logic [SET_BITS-1:0]   touch_set,
    input  logic [WAY_W-1:0]      touch_way,
    output logic [WAYS*WAY_W-1:0] rd_ages
);
    // Per set, each way carries a distinct age: 0 = newest, WAYS-1 = oldest
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] ref_age;

    assign ref_age = age_q[touch_set][touch_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < ref_age) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + WAY_W'(1);
                end
            end
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_ages[w*WAY_W +: WAY_W] = age_q[rd_set][w];
        end
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int SET_BITS   = 2,
    parameter int WAY_BITS   = 0,
    parameter int OFF_BITS   = 1,
    parameter int WRITE_BACK = 1,
    parameter int CNT_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [7:0]                    cpu_wdata,
    output logic                          cpu_busy,
    output logic                          cpu_done,
    output logic                          cpu_hit,
    output logic [7:0]                    cpu_rdata,
    output logic [CNT_W-1:0]              hit_count,
    output logic [CNT_W-1:0]              miss_count,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-OFF_BITS-1:0]    mem_addr,
    output logic [(8<<OFF_BITS)-1:0]      mem_wdata,
    output logic [(1<<OFF_BITS)-1:0]      mem_wmask,
    input  logic                          mem_ack,
    input  logic [(8<<OFF_BITS)-1:0]      mem_rdata
);
    localparam int SETS    = 1 << SET_BITS;
    localparam int WAYS    = 1 << WAY_BITS;
    localparam int BLK     = 1 << OFF_BITS;
    localparam int BLK_W   = 8 * BLK;
    localparam int TAG_W   = ADDR_W - SET_BITS - OFF_BITS;
    localparam int WAY_W   = idx_w(WAY_BITS);
    localparam bit WB_MODE = (WRITE_BACK != 0);

    // Line storage
    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [SETS-1:0][WAYS-1:0] dirty_q;
    logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
    logic [BLK_W-1:0]          data_q [SETS][WAYS];

    // Accepted request
    cache_state_e       state_q;
    logic               req_we_q;
    logic [ADDR_W-1:0]  req_addr_q;
    logic [7:0]         req_wdata_q;
    logic [WAY_W-1:0]   way_q;
    logic               was_hit_q;

    logic               done_q, hit_rsp_q;
    logic [7:0]         rdata_q;
    logic [CNT_W-1:0]   hit_cnt_q, miss_cnt_q;

    // Address fields of the incoming and the held request
    logic [TAG_W-1:0]    a_tag, p_tag;
    logic [SET_BITS-1:0] a_set, p_set;
    logic [OFF_BITS-1:0] a_off, p_off;

    assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_set = cpu_addr[OFF_BITS +: SET_BITS];
    assign a_off = cpu_addr[OFF_BITS-1:0];
    assign p_tag = req_addr_q[ADDR_W-1 -: TAG_W];
    assign p_set = req_addr_q[OFF_BITS +: SET_BITS];
    assign p_off = req_addr_q[OFF_BITS-1:0];

    // Lookup against the indexed set
    logic [WAYS*TAG_W-1:0] set_tags;
    logic [WAYS*WAY_W-1:0] set_ages;
    logic                  lk_hit;
    logic [WAY_W-1:0]      lk_hit_way, lk_victim;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tags[w*TAG_W +: TAG_W] = tag_q[a_set][w];
        end
    end

    cache_lookup #(
        .WAYS (WAYS),
        .WAY_W(WAY_W),
        .TAG_W(TAG_W)
    ) u_lookup (
        .valid     (valid_q[a_set]),
        .tags      (set_tags),
        .tag       (a_tag),
        .ages      (set_ages),
        .hit       (lk_hit),
        .hit_way   (lk_hit_way),
        .victim_way(lk_victim)
    );

    // Recency update: on a hit at accept, and when a miss completes
    logic                accept;
    logic                lru_touch;
    logic [SET_BITS-1:0] lru_set;
    logic [WAY_W-1:0]    lru_way;

    assign accept = (state_q == ST_IDLE) && cpu_req;

    always_comb begin
        lru_touch = 1'b0;
        lru_set   = a_set;
        lru_way   = lk_hit_way;
        if (accept && lk_hit) begin
            lru_touch = 1'b1;
        end else if (state_q == ST_FINISH) begin
            lru_touch = 1'b1;
            lru_set   = p_set;
            lru_way   = way_q;
        end
    end

    cache_lru #(
        .SETS    (SETS),
        .SET_BITS(SET_BITS),
        .WAYS    (WAYS),
        .WAY_W   (WAY_W)
    ) u_lru (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (a_set),
        .touch    (lru_touch),
        .touch_set(lru_set),
        .touch_way(lru_way),
        .rd_ages  (set_ages)
    );

    // Sequencer and storage updates
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            valid_q     <= '0;
            dirty_q     <= '0;
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            way_q       <= '0;
            was_hit_q   <= 1'b0;
            done_q      <= 1'b0;
            hit_rsp_q   <= 1'b0;
            rdata_q     <= '0;
            hit_cnt_q   <= '0;
            miss_cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_we_q    <= cpu_we;
                        req_addr_q  <= cpu_addr;
                        req_wdata_q <= cpu_wdata;
                        if (lk_hit) begin
                            hit_cnt_q <= hit_cnt_q + CNT_W'(1);
                            way_q     <= lk_hit_way;
                            was_hit_q <= 1'b1;
                            if (!cpu_we) begin
                                rdata_q   <= data_q[a_set][lk_hit_way][{a_off, 3'b000} +: 8];
                                done_q    <= 1'b1;
                                hit_rsp_q <= 1'b1;
                            end else begin
                                data_q[a_set][lk_hit_way][{a_off, 3'b000} +: 8] <= cpu_wdata;
                                if (WB_MODE) begin
                                    dirty_q[a_set][lk_hit_way] <= 1'b1;
                                    done_q    <= 1'b1;
                                    hit_rsp_q <= 1'b1;
                                end else begin
                                    state_q <= ST_WTHRU;
                                end
                            end
                        end else begin
                            miss_cnt_q <= miss_cnt_q + CNT_W'(1);
                            way_q      <= lk_victim;
                            was_hit_q  <= 1'b0;
                            if (cpu_we && !WB_MODE) begin
                                state_q <= ST_WTHRU;
                            end else if (valid_q[a_set][lk_victim] && dirty_q[a_set][lk_victim]) begin
                                state_q <= ST_WBACK;
                            end else begin
                                state_q <= ST_FILL;
                            end
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        dirty_q[p_set][way_q] <= 1'b0;
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        data_q[p_set][way_q]  <= mem_rdata;
                        tag_q[p_set][way_q]   <= p_tag;
                        valid_q[p_set][way_q] <= 1'b1;
                        dirty_q[p_set][way_q] <= 1'b0;
                        state_q <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    if (req_we_q) begin
                        data_q[p_set][way_q][{p_off, 3'b000} +: 8] <= req_wdata_q;
                        dirty_q[p_set][way_q] <= WB_MODE;
                    end else begin
                        rdata_q <= data_q[p_set][way_q][{p_off, 3'b000} +: 8];
                    end
                    done_q    <= 1'b1;
                    hit_rsp_q <= 1'b0;
                    state_q   <= ST_IDLE;
                end
                ST_WTHRU: begin
                    if (mem_ack) begin
                        done_q    <= 1'b1;
                        hit_rsp_q <= was_hit_q;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory side, driven from the held request
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_addr_q[ADDR_W-1:OFF_BITS];
        mem_wdata = '0;
        mem_wmask = '0;
        case (state_q)
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[p_set][way_q], p_set};
                mem_wdata = data_q[p_set][way_q];
                mem_wmask = '1;
            end
            ST_FILL: begin
                mem_req = 1'b1;
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {BLK{req_wdata_q}};
                mem_wmask = BLK'(1) << p_off;
            end
            default: ;
        endcase
    end

    assign cpu_busy   = (state_q != ST_IDLE);
    assign cpu_done   = done_q;
    assign cpu_hit    = hit_rsp_q;
    assign cpu_rdata  = rdata_q;
    assign hit_count  = hit_cnt_q;
    assign miss_count = miss_cnt_q;
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
    parameter int ADDR_W     = 4,
    parameter int OFF_BITS   = 1,
    parameter int WRITE_BACK = 1,
    parameter int CNT_W      = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cpu_busy,
    input logic                       cpu_done,
    input logic [CNT_W-1:0]           hit_count,
    input logic [CNT_W-1:0]           miss_count,
    input logic                       mem_req,
    input logic                       mem_we,
    input logic [ADDR_W-OFF_BITS-1:0] mem_addr,
    input logic [(1<<OFF_BITS)-1:0]   mem_wmask,
    input logic                       mem_ack
);
    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R12
    busy_during_mem_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> cpu_busy);

    // R10
    done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !cpu_busy);

    // R11
    hit_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + CNT_W'(1)));

    // R11
    single_count_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));

    // R8
    wt_byte_write_chk: assert property (@(posedge clk) disable iff (rst)
        (WRITE_BACK == 0) && mem_req && mem_we |-> $countones(mem_wmask) == 1);

    // R6
    wb_full_block_chk: assert property (@(posedge clk) disable iff (rst)
        (WRITE_BACK != 0) && mem_req && mem_we |-> &mem_wmask);
endmodule

bind cache_ctrl cache_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .OFF_BITS  (OFF_BITS),
    .WRITE_BACK(WRITE_BACK),
    .CNT_W     (CNT_W)
) u_cache_ctrl_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_busy  (cpu_busy),
    .cpu_done  (cpu_done),
    .hit_count (hit_count),
    .miss_count(miss_count),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wmask (mem_wmask),
    .mem_ack   (mem_ack)
);

// File: tb/test_cache_ctrl.sv
module tb_mem #(
    parameter int ADDR_W   = 4,
    parameter int OFF_BITS = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req,
    input  logic                       we,
    input  logic [ADDR_W-OFF_BITS-1:0] addr,
    input  logic [(8<<OFF_BITS)-1:0]   wdata,
    input  logic [(1<<OFF_BITS)-1:0]   wmask,
    output logic                       ack,
    output logic [(8<<OFF_BITS)-1:0]   rdata
);
    localparam int BLK = 1 << OFF_BITS;
    localparam int MEM = 1 << ADDR_W;

    logic [7:0]               bytes [MEM];
    int                       op_cnt;
    int                       lat;
    logic                     log_we   [64];
    logic [ADDR_W-OFF_BITS-1:0] log_addr [64];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM; i++) bytes[i] <= 8'hA0 + 8'(i);
            op_cnt <= 0;
            lat    <= 0;
            ack    <= 1'b0;
            rdata  <= '0;
        end else begin
            ack <= 1'b0;
            if (req && !ack) begin
                if (lat == 2) begin
                    lat <= 0;
                    ack <= 1'b1;
                    for (int k = 0; k < BLK; k++) begin
                        if (we && wmask[k]) bytes[int'(addr)*BLK + k] <= wdata[8*k +: 8];
                        rdata[8*k +: 8] <= bytes[int'(addr)*BLK + k];
                    end
                    log_we[op_cnt]   <= we;
                    log_addr[op_cnt] <= addr;
                    op_cnt <= op_cnt + 1;
                end else begin
                    lat <= lat + 1;
                end
            end
        end
    end
endmodule

module test_cache_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Direct-mapped, write-back instance
    logic       dm_req = 0, dm_we = 0;
    logic [3:0] dm_addr = 0;
    logic [7:0] dm_wdata = 0;
    logic       dm_busy, dm_done, dm_hit;
    logic [7:0] dm_rdata;
    logic [15:0] dm_hits, dm_misses;
    logic       dm_mreq, dm_mwe, dm_mack;
    logic [2:0] dm_maddr;
    logic [15:0] dm_mwdata, dm_mrdata;
    logic [1:0] dm_mwmask;

    // 2-way, write-through instance
    logic       tw_req = 0, tw_we = 0;
    logic [3:0] tw_addr = 0;
    logic [7:0] tw_wdata = 0;
    logic       tw_busy, tw_done, tw_hit;
    logic [7:0] tw_rdata;
    logic [15:0] tw_hits, tw_misses;
    logic       tw_mreq, tw_mwe, tw_mack;
    logic [2:0] tw_maddr;
    logic [15:0] tw_mwdata, tw_mrdata;
    logic [1:0] tw_mwmask;

    cache_ctrl i_cache_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(dm_req), .cpu_we(dm_we), .cpu_addr(dm_addr), .cpu_wdata(dm_wdata),
        .cpu_busy(dm_busy), .cpu_done(dm_done), .cpu_hit(dm_hit), .cpu_rdata(dm_rdata),
        .hit_count(dm_hits), .miss_count(dm_misses),
        .mem_req(dm_mreq), .mem_we(dm_mwe), .mem_addr(dm_maddr), .mem_wdata(dm_mwdata),
        .mem_wmask(dm_mwmask), .mem_ack(dm_mack), .mem_rdata(dm_mrdata)
    );

    tb_mem i_mem_dm (
        .clk(clk), .rst(rst), .req(dm_mreq), .we(dm_mwe), .addr(dm_maddr),
        .wdata(dm_mwdata), .wmask(dm_mwmask), .ack(dm_mack), .rdata(dm_mrdata)
    );

    cache_ctrl #(.SET_BITS(1), .WAY_BITS(1), .WRITE_BACK(0)) i_cache_ctrl_2w (
        .clk(clk), .rst(rst),
        .cpu_req(tw_req), .cpu_we(tw_we), .cpu_addr(tw_addr), .cpu_wdata(tw_wdata),
        .cpu_busy(tw_busy), .cpu_done(tw_done), .cpu_hit(tw_hit), .cpu_rdata(tw_rdata),
        .hit_count(tw_hits), .miss_count(tw_misses),
        .mem_req(tw_mreq), .mem_we(tw_mwe), .mem_addr(tw_maddr), .mem_wdata(tw_mwdata),
        .mem_wmask(tw_mwmask), .mem_ack(tw_mack), .mem_rdata(tw_mrdata)
    );

    tb_mem i_mem_tw (
        .clk(clk), .rst(rst), .req(tw_mreq), .we(tw_mwe), .addr(tw_maddr),
        .wdata(tw_mwdata), .wmask(tw_mwmask), .ack(tw_mack), .rdata(tw_mrdata)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Scoreboard queues: {we, hit, data} plus requirement tag
    logic [9:0] q_dm [$];
    string      n_dm [$];
    logic [9:0] q_tw [$];
    string      n_tw [$];

    // Monitor: pop on each completion pulse
    always @(negedge clk) begin
        if (!rst && dm_done) begin
            if (q_dm.size() == 0) begin
                chk("R11", "dm unexpected completion", 1, 0);
            end else begin
                logic [9:0] e;
                string      n;
                e = q_dm.pop_front();
                n = n_dm.pop_front();
                chk(n, "dm hit flag", int'(dm_hit), int'(e[8]));
                if (!e[9]) chk(n, "dm read data", int'(dm_rdata), int'(e[7:0]));
            end
        end
        if (!rst && tw_done) begin
            if (q_tw.size() == 0) begin
                chk("R11", "2w unexpected completion", 1, 0);
            end else begin
                logic [9:0] e;
                string      n;
                e = q_tw.pop_front();
                n = n_tw.pop_front();
                chk(n, "2w hit flag", int'(tw_hit), int'(e[8]));
                if (!e[9]) chk(n, "2w read data", int'(tw_rdata), int'(e[7:0]));
            end
        end
    end

    // Driver: one access, pushes its expectation, waits for the pop
    task automatic access(input bit two_way, input bit we, input logic [3:0] addr,
                          input logic [7:0] wd, input bit exp_hit, input logic [7:0] exp_data,
                          input string req);
        @(negedge clk);
        if (!two_way) begin
            q_dm.push_back({we, exp_hit, exp_data});
            n_dm.push_back(req);
            dm_req = 1; dm_we = we; dm_addr = addr; dm_wdata = wd;
            @(negedge clk);
            dm_req = 0;
            while (q_dm.size() != 0) @(posedge clk);
        end else begin
            q_tw.push_back({we, exp_hit, exp_data});
            n_tw.push_back(req);
            tw_req = 1; tw_we = we; tw_addr = addr; tw_wdata = wd;
            @(negedge clk);
            tw_req = 0;
            while (q_tw.size() != 0) @(posedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog expired: actual hung expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "busy after reset", int'(dm_busy), 0);
        chk("R10", "done after reset", int'(dm_done), 0);
        chk("R10", "mem_req after reset", int'(dm_mreq), 0);
        chk("R10", "hit count after reset", int'(dm_hits), 0);
        chk("R10", "miss count after reset", int'(dm_misses), 0);

        // R2 direct-mapped trace (R1: data from block offset)
        access(0, 0, 4'd0, 8'h00, 0, 8'hA0, "R2");
        access(0, 0, 4'd1, 8'h00, 1, 8'hA1, "R1");
        access(0, 0, 4'd7, 8'h00, 0, 8'hA7, "R2");
        access(0, 0, 4'd8, 8'h00, 0, 8'hA8, "R2");
        access(0, 0, 4'd0, 8'h00, 0, 8'hA0, "R2");

        // R5 write-back hit: no memory traffic
        access(0, 1, 4'd1, 8'h55, 1, 8'h00, "R5");
        chk("R5", "memory ops after write hit", i_mem_dm.op_cnt, 4);
        chk("R5", "memory byte 1 unchanged", int'(i_mem_dm.bytes[1]), 'hA1);

        // R6 dirty eviction: write-back of block 0 then fill of block 4
        access(0, 0, 4'd9, 8'h00, 0, 8'hA9, "R6");
        chk("R6", "memory ops after eviction", i_mem_dm.op_cnt, 6);
        chk("R6", "first op is write", int'(i_mem_dm.log_we[4]), 1);
        chk("R6", "write-back block", int'(i_mem_dm.log_addr[4]), 0);
        chk("R6", "second op is read", int'(i_mem_dm.log_we[5]), 0);
        chk("R6", "fill block", int'(i_mem_dm.log_addr[5]), 4);
        chk("R6", "dirty byte reached memory", int'(i_mem_dm.bytes[1]), 'h55);

        // R7 write-allocate
        access(0, 1, 4'd6, 8'h66, 1, 8'h00, "R5");
        access(0, 1, 4'd12, 8'h77, 0, 8'h00, "R7");
        chk("R7", "one fill for write miss", i_mem_dm.op_cnt, 7);
        chk("R7", "fill is a read", int'(i_mem_dm.log_we[6]), 0);
        chk("R7", "memory byte 12 unchanged", int'(i_mem_dm.bytes[12]), 'hAC);
        access(0, 0, 4'd12, 8'h00, 1, 8'h77, "R7");
        access(0, 0, 4'd13, 8'h00, 1, 8'hAD, "R1");
        access(0, 0, 4'd14, 8'h00, 0, 8'hAE, "R6");
        chk("R6", "write-back of block 3", int'(i_mem_dm.log_addr[7]), 3);
        chk("R6", "byte 6 reached memory", int'(i_mem_dm.bytes[6]), 'h66);
        chk("R11", "dm hit count", int'(dm_hits), 5);
        chk("R11", "dm miss count", int'(dm_misses), 7);

        // R3 two-way trace
        access(1, 0, 4'd0, 8'h00, 0, 8'hA0, "R3");
        access(1, 0, 4'd1, 8'h00, 1, 8'hA1, "R3");
        access(1, 0, 4'd7, 8'h00, 0, 8'hA7, "R3");
        access(1, 0, 4'd8, 8'h00, 0, 8'hA8, "R4");
        access(1, 0, 4'd0, 8'h00, 1, 8'hA0, "R4");
        // R4 least recently used replacement
        access(1, 0, 4'd4, 8'h00, 0, 8'hA4, "R4");
        access(1, 0, 4'd0, 8'h00, 1, 8'hA0, "R4");
        access(1, 0, 4'd8, 8'h00, 0, 8'hA8, "R4");
        access(1, 0, 4'd0, 8'h00, 1, 8'hA0, "R4");
        access(1, 0, 4'd4, 8'h00, 0, 8'hA4, "R4");

        // R8 write-through hit
        access(1, 1, 4'd0, 8'h33, 1, 8'h00, "R8");
        chk("R8", "byte 0 written through", int'(i_mem_dm.bytes[0]) == 'hA0 ? int'(i_mem_tw.bytes[0]) : -1, 'h33);
        chk("R8", "neighbour byte untouched", int'(i_mem_tw.bytes[1]), 'hA1);
        access(1, 0, 4'd0, 8'h00, 1, 8'h33, "R8");

        // R9 no-write-allocate miss
        access(1, 1, 4'd10, 8'h44, 0, 8'h00, "R9");
        chk("R9", "op was a write", int'(i_mem_tw.log_we[i_mem_tw.op_cnt-1]), 1);
        chk("R9", "byte 10 written", int'(i_mem_tw.bytes[10]), 'h44);
        access(1, 0, 4'd10, 8'h00, 0, 8'h44, "R9");
        chk("R11", "2w hit count", int'(tw_hits), 6);
        chk("R11", "2w miss count", int'(tw_misses), 8);

        // R10 reset drops valid lines and counters
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R10", "hit count cleared", int'(dm_hits), 0);
        access(0, 0, 4'd0, 8'h00, 0, 8'hA0, "R10");
        chk("R10", "miss counted after reset", int'(dm_misses), 1);

        report();
    end
endmodule